// File: doc/BRIEF.md
# Serial Transmit Path with Flow Control

This block turns parallel characters from a CPU into a serial bit stream. The CPU writes a character into a single holding register whenever the ready output is high. At each character boundary the character moves into a shift register that drives the serial line. Every bit boundary is a falling edge of an external transmit clock. That clock is sampled in the block's own clock domain. In asynchronous mode each bit lasts 1, 16 or 64 transmit-clock periods, and a character is framed with a start bit, an optional parity bit and one or two stop bits. In synchronous mode each falling edge sends one bit, with no framing. When the line runs out of data, a programmed sync character is sent in its place.

Flow control combines a clear-to-send input, which is active low, with a transmit-enable command bit. While either of them withholds permission, the holding register refuses new characters. A character already accepted is still transmitted in full, even if it has not yet reached the shift register. Writes made while permission is withheld are lost, and in synchronous mode the sync fill stops, so the line rests at mark. The empty output tells the CPU when no data character remains, either waiting or on the line. Sync fill characters do not count as data for this output.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, with the enable command low, `txd` is 1, `tx_empty` is 1 and `tx_rdy` is 0.
- R2: `tx_rdy` is 1 exactly when `tx_en` is 1, `cts_n` is 0 and the holding register is empty. A write strobe while `tx_rdy` is 1 is accepted, and one while it is 0 is discarded.
- R3: In asynchronous mode (`sync_mode` 0) a frame is a start bit of 0, then the 8 data bits least significant first, then the parity bit if enabled, then one stop bit of 1, or two if `two_stop` is 1. When no frame is being sent the line is 1.
- R4: The parity bit, present when `par_en` is 1, is the XOR of the data bits when `par_odd` is 0 (even parity) and the complement of that XOR when `par_odd` is 1.
- R5: In asynchronous mode `rate_sel` picks the transmit-clock falling edges per bit: 0 gives 1, 1 gives 16, 2 or 3 give 64. Every bit holds for exactly that many edges, and the first start bit appears within one bit period of the write.
- R6: `txd` changes only on the clock edge that first samples a falling edge of `txc`. With `txc` held still, the line does not move.
- R7: A character waiting in the holding register starts on the bit boundary right after the previous frame's last stop bit, with no idle gap.
- R8: A character accepted before `cts_n` rises or `tx_en` falls is still sent in full. This holds both for one already in the shift register and for one still in the holding register.
- R9: A write made while transmission is not permitted produces no frame. The line stays at 1 and `tx_empty` stays 1.
- R10: `tx_empty` goes to 0 in the cycle after an accepted write. It returns to 1 at the bit boundary that ends the last data character, provided no other character is waiting.
- R11: In synchronous mode a character is its 8 data bits, least significant first, one per transmit-clock falling edge. There are no start, stop or parity bits, and `rate_sel` and `par_en` are ignored.
- R12: In synchronous mode, at a character boundary with nothing waiting, `sync_char` is sent if transmission is permitted, and `tx_empty` stays 1 during this fill. If transmission is not permitted, the line stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| txc | input | 1 | Transmit clock; its falling edges mark bit boundaries |
| sync_mode | input | 1 | 1 selects synchronous mode, 0 selects asynchronous framing |
| rate_sel | input | 2 | Asynchronous rate factor: 0 gives x1, 1 gives x16, 2 or 3 give x64 |
| par_en | input | 1 | Add a parity bit in asynchronous mode |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| sync_char | input | 8 | Fill character for synchronous mode |
| tx_en | input | 1 | Transmit-enable command bit |
| cts_n | input | 1 | Clear to send, active low |
| wr_stb | input | 1 | One-cycle write strobe for `wr_data` |
| wr_data | input | 8 | Character to transmit |
| txd | output | 1 | Serial output, idle at 1 |
| tx_rdy | output | 1 | The holding register can take a character |
| tx_empty | output | 1 | No data character is waiting or on the line |

## Verification
The main path is driven with random characters under random parity, stop-bit and rate settings. Pairs of characters are written back to back, so a wrong bit count, bit order or rate factor shows up as a bad character, and a missing handoff shows up as a gap between frames. Directed sequences drop permission, through `cts_n` and through `tx_en`, while one character is on the line and another is waiting, and then write into the disabled block. This separates "finish what was accepted" from "refuse what comes later". The synchronous run uses a random fill character with a data character placed between fill characters. It shows whether fill starts and stops on the correct boundaries, whether framing settings leak into synchronous mode, and whether `tx_empty` treats fill as data.

// File: rtl/uart_tx_pkg.sv
// Shared types for the serial transmit path.
// Assumes the rate selector is a two-bit field whose top code aliases x64.
package uart_tx_pkg;

    // Encoding of the asynchronous rate-factor selector.
    typedef enum logic [1:0] {
        RATE_X1   = 2'd0,
        RATE_X16  = 2'd1,
        RATE_X64  = 2'd2,
        RATE_X64B = 2'd3
    } rate_e;

    // Framing options that the shift stage uses.
    typedef struct packed {
        logic sync_mode;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/tx_bit_clock.sv
// Bit-boundary generator: it samples the transmit clock, detects falling
// edges and divides them by the selected rate factor in asynchronous mode.
// Assumes txc is stable around clk edges (slower than clk, same domain or
// already synchronised) and that rate_sel changes only while the line is idle.
module tx_bit_clock
    import uart_tx_pkg::*;
#(
    parameter int MID_FACTOR = 16,
    parameter int HI_FACTOR  = 64,
    localparam int DIV_W     = $clog2(HI_FACTOR)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txc,
    input  logic       sync_mode,
    input  logic [1:0] rate_sel,
    output logic       bit_tick
);

    logic             txc_q;
    logic             txc_fall;
    logic             wrap;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;

    // Last divider count for the selected factor.
    always_comb begin
        case (rate_e'(rate_sel))
            RATE_X1:  div_last = '0;
            RATE_X16: div_last = DIV_W'(MID_FACTOR - 1);
            default:  div_last = DIV_W'(HI_FACTOR - 1);
        endcase
    end

    // Keep the previous transmit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) txc_q <= 1'b0;
        else        txc_q <= txc;
    end

    assign txc_fall = txc_q & ~txc;
    assign wrap     = sync_mode || (div_cnt >= div_last);
    assign bit_tick = txc_fall & wrap;

    // Count falling edges within one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_cnt <= '0;
        else if (txc_fall) div_cnt <= wrap ? '0 : div_cnt + 1'b1;
    end

    AST_TICK_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (!txc && $past(txc)));  // R6

endmodule

// File: rtl/tx_hold_buf.sv
// One-character holding register between the CPU and the shift stage.
// It accepts a write only while transmission is permitted and empty, and
// it releases its character when the shift stage takes it. Release does not
// depend on permission, so an accepted character is always sent.
module tx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              permit,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic              rdy,
    output logic [DATA_W-1:0] data
);

    assign rdy = permit & ~full;

    // Fill on an accepted write, empty when the shifter takes the character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && rdy) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && permit && !full) |=> full);  // R2

    AST_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rdy && !take) |=> ($stable(data) && $stable(full)));  // R9

    AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);  // R8

endmodule

// File: rtl/tx_frame_shifter.sv
// Frame builder and shift register. At a character boundary it loads the
// held character (or the sync character in synchronous mode when permitted),
// framed per the configuration, and it sends one bit per bit tick, least
// significant first. It also reports whether a data character is on the line.
// Assumes the framing configuration is stable while a character is sent.
module tx_frame_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    localparam int FRAME_W = DATA_W + 4,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  frame_cfg_t        cfg,
    input  logic              permit,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [DATA_W-1:0] sync_char,
    output logic              take,
    output logic              txd,
    output logic              data_busy
);

    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   bits_left;
    logic [CNT_W-1:0]   frame_len;
    logic [DATA_W-1:0]  src;
    logic               boundary;
    logic               load_data;
    logic               load_sync;

    assign boundary  = (bits_left == '0);
    assign load_data = bit_tick & boundary & hold_full;
    assign load_sync = bit_tick & boundary & ~hold_full & cfg.sync_mode & permit;
    assign take      = load_data;
    assign src       = load_data ? hold_data : sync_char;

    // Build the framed character and its length in bits.
    always_comb begin
        frame = '1;
        if (cfg.sync_mode) begin
            frame[DATA_W-1:0] = src;
            frame_len         = CNT_W'(DATA_W);
        end else begin
            frame[0]        = 1'b0;
            frame[DATA_W:1] = src;
            if (cfg.par_en) frame[DATA_W+1] = cfg.par_odd ^ (^src);
            frame_len = CNT_W'(DATA_W + 2) + CNT_W'(cfg.par_en) + CNT_W'(cfg.two_stop);
        end
    end

    // Load a new character at a boundary, otherwise shift one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            bits_left <= '0;
            txd       <= 1'b1;
            data_busy <= 1'b0;
        end else if (load_data || load_sync) begin
            txd       <= frame[0];
            shreg     <= {1'b1, frame[FRAME_W-1:1]};
            bits_left <= frame_len - 1'b1;
            data_busy <= load_data;
        end else if (bit_tick && !boundary) begin
            txd       <= shreg[0];
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - 1'b1;
        end else if (bit_tick) begin
            txd       <= 1'b1;
            data_busy <= 1'b0;
        end
    end

    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));  // R6

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_data && !cfg.sync_mode) |=> !txd);  // R3

    AST_FILL_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        load_sync |=> !data_busy);  // R12

    AST_MARK_WHEN_BARRED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && boundary && !hold_full && !permit) |=> txd);  // R12

endmodule

// File: rtl/uart_tx_path.sv
// Top of the serial transmit path: it ties the bit clock, holding register
// and frame shifter together and applies flow control. Transmission is
// permitted while the enable command is set and clear-to-send is low.
// Assumes register decoding lives outside and drives the option inputs.
module uart_tx_path
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MID_FACTOR = 16,
    parameter int HI_FACTOR  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txc,
    input  logic              sync_mode,
    input  logic [1:0]        rate_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic [DATA_W-1:0] sync_char,
    input  logic              tx_en,
    input  logic              cts_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_empty
);

    logic              permit;
    logic              bit_tick;
    logic              hold_full;
    logic              take;
    logic              data_busy;
    logic [DATA_W-1:0] hold_data;
    frame_cfg_t        cfg;

    assign permit   = tx_en & ~cts_n;
    assign cfg      = '{sync_mode: sync_mode, par_en: par_en,
                        par_odd: par_odd, two_stop: two_stop};
    assign tx_empty = ~hold_full & ~data_busy;

    tx_bit_clock #(
        .MID_FACTOR (MID_FACTOR),
        .HI_FACTOR  (HI_FACTOR)
    ) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .txc       (txc),
        .sync_mode (sync_mode),
        .rate_sel  (rate_sel),
        .bit_tick  (bit_tick)
    );

    tx_hold_buf #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .permit  (permit),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .rdy     (tx_rdy),
        .data    (hold_data)
    );

    tx_frame_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .cfg       (cfg),
        .permit    (permit),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .sync_char (sync_char),
        .take      (take),
        .txd       (txd),
        .data_busy (data_busy)
    );

    AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_rdy) |=> !tx_empty);  // R10

    AST_READY_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !cts_n && tx_empty) |-> tx_rdy);  // R2

endmodule

// File: tb/sim_uart_tx_path.sv
module sim_uart_tx_path;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txc = 1'b1;
    logic       sync_mode = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic [7:0] sync_char = 8'h00;
    logic       tx_en = 1'b0;
    logic       cts_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd;
    logic       tx_rdy;
    logic       tx_empty;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_tx_path u0 (
        .clk(clk), .rst_n(rst_n), .txc(txc), .sync_mode(sync_mode),
        .rate_sel(rate_sel), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .sync_char(sync_char), .tx_en(tx_en),
        .cts_n(cts_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
    );

    function automatic int factor_of(input logic [1:0] r);
        case (r)
            2'd0:    return 1;
            2'd1:    return 16;
            default: return 64;
        endcase
    endfunction

    function automatic logic parity_of(input logic [7:0] d, input logic odd);
        return odd ? ~(^d) : (^d);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One transmit-clock period; returns at a negedge after the fall is seen.
    task automatic fall_once();
        @(negedge clk) txc = 1'b1;
        @(negedge clk) txc = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic wait_start(output int n);
        n = 0;
        while (txd !== 1'b0 && n < 300) begin
            fall_once();
            n++;
        end
    endtask

    task automatic recv_rest(input logic [7:0] d, input int f, input string tag);
        logic [7:0] got;
        logic       p;
        logic       s1;
        logic       s2;
        for (int i = 0; i < 8; i++) begin
            repeat (f) fall_once();
            got[i] = txd;
        end
        chk(got == d, {tag, " R3 R5 data bits"}, 32'(got), 32'(d));
        if (par_en) begin
            repeat (f) fall_once();
            p = txd;
            chk(p == parity_of(d, par_odd), {tag, " R4 parity"}, 32'(p),
                32'(parity_of(d, par_odd)));
        end
        repeat (f) fall_once();
        s1 = txd;
        chk(s1 == 1'b1, {tag, " R3 stop bit"}, 32'(s1), 32'd1);
        if (two_stop) begin
            repeat (f) fall_once();
            s2 = txd;
            chk(s2 == 1'b1, {tag, " R3 second stop"}, 32'(s2), 32'd1);
        end
    endtask

    task automatic grab8(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            fall_once();
            b[i] = txd;
        end
    endtask

    task automatic idle_check(input int nfalls, input string tag);
        int bad = 0;
        for (int i = 0; i < nfalls; i++) begin
            fall_once();
            if (txd !== 1'b1) bad++;
        end
        chk(bad == 0, tag, 32'(bad), 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        int n;
        int f;
        logic [7:0] c1, c2, b;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 line idle", 32'(txd), 32'd1);
        chk(tx_empty == 1'b1, "R1 empty", 32'(tx_empty), 32'd1);
        chk(tx_rdy == 1'b0, "R1 not ready", 32'(tx_rdy), 32'd0);

        tx_en = 1'b1;
        @(negedge clk);
        chk(tx_rdy == 1'b1, "R2 ready once enabled", 32'(tx_rdy), 32'd1);

        // txc held still: no bit may leave.
        write_char(8'hA5);
        chk(tx_empty == 1'b0, "R10 empty drops after write", 32'(tx_empty), 32'd0);
        chk(tx_rdy == 1'b0, "R2 ready drops when full", 32'(tx_rdy), 32'd0);
        repeat (20) @(negedge clk);
        chk(txd == 1'b1, "R6 no move without txc fall", 32'(txd), 32'd1);
        wait_start(n);
        chk(n == 1, "R5 x1 start on first fall", 32'(n), 32'd1);
        recv_rest(8'hA5, 1, "directed");
        fall_once();
        chk(tx_empty == 1'b1, "R10 empty after last stop", 32'(tx_empty), 32'd1);

        // Random back-to-back pairs under random framing.
        for (int k = 0; k < 10; k++) begin
            rate_sel = 2'($urandom % 4);
            par_en   = 1'($urandom);
            par_odd  = 1'($urandom);
            two_stop = 1'($urandom);
            f  = factor_of(rate_sel);
            c1 = 8'($urandom);
            c2 = 8'($urandom);
            write_char(c1);
            wait_start(n);
            chk(n >= 1 && n <= f, "R5 first start within a bit", 32'(n), 32'(f));
            chk(tx_rdy == 1'b1, "R2 ready after handoff", 32'(tx_rdy), 32'd1);
            write_char(c2);
            recv_rest(c1, f, "rand c1");
            wait_start(n);
            chk(n == f, "R7 no gap between frames", 32'(n), 32'(f));
            recv_rest(c2, f, "rand c2");
            chk(tx_empty == 1'b0, "R10 busy on last stop", 32'(tx_empty), 32'd0);
            repeat (f) fall_once();
            chk(tx_empty == 1'b1, "R10 empty after frame", 32'(tx_empty), 32'd1);
            chk(txd == 1'b1, "R3 idle mark", 32'(txd), 32'd1);
        end

        // Disable through clear-to-send with a character still held.
        rate_sel = 2'd0; par_en = 1'b0; two_stop = 1'b0;
        write_char(8'h3C);
        cts_n = 1'b1;
        @(negedge clk);
        chk(tx_rdy == 1'b0, "R2 ready low while cts high", 32'(tx_rdy), 32'd0);
        write_char(8'hFF);
        wait_start(n);
        chk(n == 1, "R8 held char starts after cts", 32'(n), 32'd1);
        recv_rest(8'h3C, 1, "cts R8");
        idle_check(30, "R9 refused write never sent");
        chk(tx_empty == 1'b1, "R9 empty after refused write", 32'(tx_empty), 32'd1);
        cts_n = 1'b0;
        @(negedge clk);
        chk(tx_rdy == 1'b1, "R2 ready back after cts", 32'(tx_rdy), 32'd1);

        // Disable through the command with one char on line, one held.
        write_char(8'h96);
        wait_start(n);
        write_char(8'h4B);
        tx_en = 1'b0;
        recv_rest(8'h96, 1, "cmd R8 c1");
        wait_start(n);
        chk(n == 1, "R8 held char follows after command off", 32'(n), 32'd1);
        recv_rest(8'h4B, 1, "cmd R8 c2");
        idle_check(20, "R9 line idle after disable");
        write_char(8'h00);
        chk(tx_empty == 1'b1, "R9 empty stays after disabled write", 32'(tx_empty), 32'd1);
        idle_check(20, "R9 disabled write not sent");
        tx_en = 1'b1;

        // Synchronous mode: fill, data between fill, then disabled fill.
        c1 = 8'($urandom);
        c2 = 8'($urandom);
        @(negedge clk) begin
            sync_mode = 1'b1;
            sync_char = 8'($urandom) | 8'h01;
            par_en    = 1'b1;
            rate_sel  = 2'($urandom % 4);
        end
        for (int k = 0; k < 3; k++) begin
            grab8(b);
            chk(b == sync_char, "R12 fill character", 32'(b), 32'(sync_char));
            chk(tx_empty == 1'b1, "R12 empty during fill", 32'(tx_empty), 32'd1);
        end
        write_char(c1);
        chk(tx_empty == 1'b0, "R10 sync write clears empty", 32'(tx_empty), 32'd0);
        grab8(b);
        chk(b == c1, "R11 sync data bits", 32'(b), 32'(c1));
        grab8(b);
        chk(b == sync_char, "R12 fill resumes", 32'(b), 32'(sync_char));
        chk(tx_empty == 1'b1, "R12 empty back during fill", 32'(tx_empty), 32'd1);
        write_char(c2);
        grab8(b);
        chk(b == c2, "R11 second sync data", 32'(b), 32'(c2));
        tx_en = 1'b0;
        idle_check(16, "R12 no fill while disabled");
        @(negedge clk) begin sync_mode = 1'b0; tx_en = 1'b1; end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule